// File: doc/BRIEF.md
# NAND Flash Command-Cycle Sequencer

This block turns a single command word into one complete transaction on a raw 8-bit NAND flash bus. When the word is accepted, the block latches the two opcode bytes, the 64 bits of address, the outgoing data word and the timing settings. It selects one chip and runs the enabled phases in a fixed order: a first opcode byte with CLE high, a programmable run of address bytes with ALE high, and a short programmed-I/O data phase of up to four bytes. A second opcode byte goes either before or after the data, and an optional wait for the device's ready line can close the sequence.

Every byte cycle is built from a strobe-low and a strobe-high interval. Each interval lasts a programmable number of clock cycles. Write-type bytes use the WE_n strobe and read bytes use RE_n. A one-cycle done pulse marks the end of each sequence. Bytes read from the device collect in a 32-bit receive word, lowest lane first. Software-side registers live outside the block and present their contents on the input ports.

Top module: `nand_seq`

## Requirements
- R1: After reset every chip enable is high, CLE and ALE are low, WE_n and RE_n are high, busy and done are low and the receive word is zero.
- R2: A command word is accepted only while idle and only with bit 31 set. Bit 8+n of the word drives ce_n[n] low. That value holds for the whole sequence, and all enables return high in the cycle done is raised.
- R3: Bit 30 enables a first opcode byte (op_first, CLE high). Bit 29 enables the address phase (ALE high). In the address phase, bits 3:0 hold the byte count minus one, and values above 7 mean 8 bytes. Address bytes go out least significant first: addr_lo bytes 0..3, then addr_hi bytes 0..3.
- R4: Bit 25 enables a second opcode byte (op_second, CLE high). With bit 24 clear it goes before the data phase. With bit 24 set it goes after the data phase.
- R5: With bits 28 and 27 set, the data phase sends bytes on WE_n from tx_word lane 0 upward. Bits 23:20 hold the byte count minus one, and values above 3 mean 4 bytes.
- R6: With bits 28 and 26 set and bit 27 clear, the data phase strobes RE_n once per byte. At each RE_n rising edge, io_in is stored into the next receive lane, starting at lane 0. Lanes not reached read zero, because the receive word clears when a command is accepted.
- R7: The timing word holds five fields. Bits 3:0 give the WE_n low width and bits 5:4 the WE_n high width. Bits 9:6 give the RE_n low width and bits 11:10 the RE_n high width. Bits 13:12 give the chip-enable setup time before the first strobe. Every width or time is the field value plus one, in cycles.
- R8: With bit 16 set, after the last byte the block waits timing bits 17:14 plus one cycles. It then waits for the two-flop-synchronised rb_in to read high before raising done. While rb_in stays low, done never rises.
- R9: Done is high for exactly one cycle at the end of each accepted sequence, and busy is low in that cycle.
- R10: A command word presented while a sequence runs is dropped: it changes neither the chip enable nor the byte stream, and it causes no second done. A word with bit 31 clear starts nothing.
- R11: Without bit 28 there is no data phase, even if bit 27 or bit 26 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Presents cmd_word for one cycle |
| cmd_word | input | 32 | Command word (start, phase enables, sizes, chip select) |
| op_first | input | 8 | First opcode byte |
| op_second | input | 8 | Second opcode byte |
| addr_lo | input | 32 | Address bytes 0..3 |
| addr_hi | input | 32 | Address bytes 4..7 |
| tx_word | input | 8*NDATA | Transmit data, lane 0 first |
| timing | input | 18 | Strobe widths, setup and ready-wait delay |
| rb_in | input | 1 | Device ready line, high when ready |
| io_in | input | 8 | Bus data from the device |
| ce_n | output | NCHIP | Active-low chip enables |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe |
| re_n | output | 1 | Read strobe |
| io_out | output | 8 | Bus data to the device |
| io_oe | output | 1 | Drive enable for io_out |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-sequence pulse |
| rx_word | output | 8*NDATA | Received data, lane 0 first |

## Verification
The hardest situation to reach is a sequence parked in the ready wait. All its bytes are on the bus, but done must still stay low. From the ports this is only visible as the lack of a pulse. So the bench holds rb_in low through a full read sequence, confirms the whole byte stream and the steady chip enable while waiting far past the delay, and only then releases the line. A second hard case is a new command word arriving mid-sequence. The bench injects one during a slow address phase, using wide strobes, and checks that the chip enable, the byte log and the done count are unaffected.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    // command word bit positions
    localparam int B_GO    = 31;
    localparam int B_CMD1  = 30;
    localparam int B_ADDR  = 29;
    localparam int B_PIO   = 28;
    localparam int B_TX    = 27;
    localparam int B_RX    = 26;
    localparam int B_CMD2  = 25;
    localparam int B_LATE  = 24;
    localparam int B_RBW   = 16;
    localparam int LEN_LSB = 20;
    localparam int CE_LSB  = 8;

    // timing word field positions
    localparam int TIM_W   = 18;
    localparam int T_WL    = 0;
    localparam int T_WH    = 4;
    localparam int T_RL    = 6;
    localparam int T_RH    = 10;
    localparam int T_SU    = 12;
    localparam int T_TWB   = 14;

    typedef enum logic [3:0] {
        PH_IDLE  = 4'd0,
        PH_SETUP = 4'd1,
        PH_CMD1  = 4'd2,
        PH_ADDR  = 4'd3,
        PH_CMD2A = 4'd4,
        PH_DATA  = 4'd5,
        PH_CMD2B = 4'd6,
        PH_TWB   = 4'd7,
        PH_RBW   = 4'd8
    } phase_t;

    // first enabled phase strictly after cur; checked last-to-first so the earliest wins
    function automatic phase_t next_phase(input phase_t cur, input logic [31:0] c);
        phase_t r;
        r = PH_IDLE;
        if (cur < PH_TWB   && c[B_RBW])                       r = PH_TWB;
        if (cur < PH_CMD2B && c[B_CMD2] && c[B_LATE])         r = PH_CMD2B;
        if (cur < PH_DATA  && c[B_PIO] && (c[B_TX] || c[B_RX])) r = PH_DATA;
        if (cur < PH_CMD2A && c[B_CMD2] && !c[B_LATE])        r = PH_CMD2A;
        if (cur < PH_ADDR  && c[B_ADDR])                      r = PH_ADDR;
        if (cur < PH_CMD1  && c[B_CMD1])                      r = PH_CMD1;
        return r;
    endfunction

    function automatic logic is_read(input phase_t p, input logic [31:0] c);
        return (p == PH_DATA) && c[B_RX] && !c[B_TX];
    endfunction

    function automatic logic [3:0] strobe_low(input phase_t p, input logic [31:0] c,
                                              input logic [TIM_W-1:0] t);
        return is_read(p, c) ? t[T_RL +: 4] : t[T_WL +: 4];
    endfunction

    function automatic logic [3:0] strobe_high(input phase_t p, input logic [31:0] c,
                                               input logic [TIM_W-1:0] t);
        return {2'b00, (is_read(p, c) ? t[T_RH +: 2] : t[T_WH +: 2])};
    endfunction

endpackage

// File: rtl/nand_seq_rbsync.sv
module nand_seq_rbsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_async,
    output logic rb_ready
);
    logic [STAGES-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], rb_async};
    end

    assign rb_ready = sync_q[STAGES-1];
endmodule

// File: rtl/nand_seq_addr_pick.sv
module nand_seq_addr_pick #(
    parameter int NBYTES = 8,
    localparam int IW = $clog2(NBYTES)
) (
    input  logic [8*NBYTES-1:0] bytes_in,
    input  logic [IW-1:0]       sel,
    output logic [7:0]          byte_out
);
    logic [7:0] lanes [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lanes[g] = bytes_in[8*g +: 8];
    end

    assign byte_out = lanes[sel];
endmodule

// File: rtl/nand_seq_ce_dec.sv
module nand_seq_ce_dec #(
    parameter int NCHIP = 8
) (
    input  logic             active,
    input  logic [NCHIP-1:0] sel,
    output logic [NCHIP-1:0] ce_n
);
    for (genvar g = 0; g < NCHIP; g++) begin : g_ce
        assign ce_n[g] = ~(active & sel[g]);
    end
endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int NCHIP = 8,
    parameter int NDATA = 4,
    localparam int DW = 8 * NDATA,
    localparam int ABYTES = 8,
    localparam int IDX_W = $clog2(ABYTES),
    localparam int LANE_W = (NDATA > 1) ? $clog2(NDATA) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [31:0]      cmd_word,
    input  logic [7:0]       op_first,
    input  logic [7:0]       op_second,
    input  logic [31:0]      addr_lo,
    input  logic [31:0]      addr_hi,
    input  logic [DW-1:0]    tx_word,
    input  logic [TIM_W-1:0] timing,
    input  logic             rb_in,
    input  logic [7:0]       io_in,
    output logic [NCHIP-1:0] ce_n,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic             re_n,
    output logic [7:0]       io_out,
    output logic             io_oe,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    rx_word
);
    typedef struct packed {
        phase_t             ph;
        logic               hi;
        logic [3:0]         cnt;
        logic [IDX_W-1:0]   idx;
        logic [31:0]        cmd;
        logic [7:0]         op1;
        logic [7:0]         op2;
        logic [8*ABYTES-1:0] adr;
        logic [DW-1:0]      txd;
        logic [DW-1:0]      rx;
        logic [TIM_W-1:0]   tim;
        logic               done;
    } st_t;

    st_t st_d, st_q;

    logic             rb_ready;
    logic             rd;
    logic             byte_ph;
    logic             adv;
    phase_t           nxt;
    logic [IDX_W-1:0] last_idx;
    logic [LANE_W-1:0] lane;
    logic [7:0]       addr_byte;
    logic [3:0]       len_f;

    nand_seq_rbsync #(.STAGES(2)) u_rb (
        .clk(clk), .rst_n(rst_n), .rb_async(rb_in), .rb_ready(rb_ready)
    );

    nand_seq_addr_pick #(.NBYTES(ABYTES)) u_addr (
        .bytes_in(st_q.adr), .sel(st_q.idx), .byte_out(addr_byte)
    );

    nand_seq_ce_dec #(.NCHIP(NCHIP)) u_ce (
        .active(busy), .sel(st_q.cmd[CE_LSB +: NCHIP]), .ce_n(ce_n)
    );

    assign lane    = st_q.idx[LANE_W-1:0];
    assign rd      = is_read(st_q.ph, st_q.cmd);
    assign byte_ph = (st_q.ph == PH_CMD1) || (st_q.ph == PH_ADDR) || (st_q.ph == PH_CMD2A)
                  || (st_q.ph == PH_DATA) || (st_q.ph == PH_CMD2B);
    assign len_f   = st_q.cmd[LEN_LSB +: 4];

    always_comb begin
        case (st_q.ph)
            PH_ADDR: last_idx = st_q.cmd[3] ? IDX_W'(ABYTES - 1) : st_q.cmd[IDX_W-1:0];
            PH_DATA: last_idx = (len_f > 4'(NDATA - 1)) ? IDX_W'(NDATA - 1) : IDX_W'(len_f);
            default: last_idx = '0;
        endcase
    end

    // next-state computation
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        adv       = 1'b0;
        nxt       = PH_IDLE;
        case (st_q.ph)
            PH_IDLE: begin
                if (cmd_wr && cmd_word[B_GO]) begin
                    st_d.cmd        = cmd_word;
                    st_d.cmd[B_GO]  = 1'b0;
                    st_d.op1        = op_first;
                    st_d.op2        = op_second;
                    st_d.adr        = {addr_hi, addr_lo};
                    st_d.txd        = tx_word;
                    st_d.tim        = timing;
                    st_d.rx         = '0;
                    st_d.ph         = PH_SETUP;
                    st_d.hi         = 1'b0;
                    st_d.idx        = '0;
                    st_d.cnt        = {2'b00, timing[T_SU +: 2]};
                end
            end
            PH_SETUP: begin
                if (st_q.cnt != 0) st_d.cnt = st_q.cnt - 4'd1;
                else begin adv = 1'b1; nxt = next_phase(PH_SETUP, st_q.cmd); end
            end
            PH_TWB: begin
                if (st_q.cnt != 0) st_d.cnt = st_q.cnt - 4'd1;
                else begin adv = 1'b1; nxt = PH_RBW; end
            end
            PH_RBW: begin
                if (rb_ready) begin adv = 1'b1; nxt = PH_IDLE; end
            end
            default: begin
                if (st_q.cnt != 0) begin
                    st_d.cnt = st_q.cnt - 4'd1;
                end else if (!st_q.hi) begin
                    if (rd) st_d.rx[8*lane +: 8] = io_in;
                    st_d.hi  = 1'b1;
                    st_d.cnt = strobe_high(st_q.ph, st_q.cmd, st_q.tim);
                end else if (st_q.idx == last_idx) begin
                    adv = 1'b1;
                    nxt = next_phase(st_q.ph, st_q.cmd);
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                    st_d.hi  = 1'b0;
                    st_d.cnt = strobe_low(st_q.ph, st_q.cmd, st_q.tim);
                end
            end
        endcase
        if (adv) begin
            st_d.ph   = nxt;
            st_d.hi   = 1'b0;
            st_d.idx  = '0;
            st_d.cnt  = (nxt == PH_TWB) ? st_q.tim[T_TWB +: 4] : strobe_low(nxt, st_q.cmd, st_q.tim);
            st_d.done = (nxt == PH_IDLE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ph <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // bus outputs
    always_comb begin
        case (st_q.ph)
            PH_CMD1:           io_out = st_q.op1;
            PH_CMD2A, PH_CMD2B: io_out = st_q.op2;
            PH_ADDR:           io_out = addr_byte;
            PH_DATA:           io_out = st_q.txd[8*lane +: 8];
            default:           io_out = 8'h00;
        endcase
    end

    assign busy    = (st_q.ph != PH_IDLE);
    assign done    = st_q.done;
    assign cle     = (st_q.ph == PH_CMD1) || (st_q.ph == PH_CMD2A) || (st_q.ph == PH_CMD2B);
    assign ale     = (st_q.ph == PH_ADDR);
    assign we_n    = !(byte_ph && !rd && !st_q.hi);
    assign re_n    = !(rd && !st_q.hi);
    assign io_oe   = byte_ph && !rd;
    assign rx_word = st_q.rx;

    logic unused_bits;
    assign unused_bits = ^{st_q.cmd[31], st_q.cmd[19:17], st_q.cmd[7:4]};

    // R9: done lasts one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R9: done only when idle
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
    // R3: CLE and ALE never together
    a_r3_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
    // R7: never both strobes low
    a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n));
    // R2: chip enable steady while running
    a_r2_ce_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ce_n));
    // R2: at most one chip selected
    a_r2_ce_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~ce_n));
    // R8: no done while device not ready
    a_r8_wait_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_RBW && !rb_ready) |=> !done);
endmodule

// File: tb/nand_seq_test.sv
module nand_seq_test;
    localparam int NCHIP = 8;
    localparam int NDATA = 4;

    localparam logic [31:0] C_GO = 32'h8000_0000, C_CMD1 = 32'h4000_0000, C_ADDR = 32'h2000_0000,
                            C_PIO = 32'h1000_0000, C_TX = 32'h0800_0000, C_RX = 32'h0400_0000,
                            C_CMD2 = 32'h0200_0000, C_LATE = 32'h0100_0000, C_RBW = 32'h0001_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wr = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [7:0] op_first = '0, op_second = '0;
    logic [31:0] addr_lo = '0, addr_hi = '0;
    logic [31:0] tx_word = '0;
    logic [17:0] timing = '0;
    logic rb_in = 1'b1;
    logic [7:0] io_in = '0;
    logic [NCHIP-1:0] ce_n;
    logic cle, ale, we_n, re_n, io_oe, busy, done;
    logic [7:0] io_out;
    logic [31:0] rx_word;

    nand_seq #(.NCHIP(NCHIP), .NDATA(NDATA)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .op_first(op_first), .op_second(op_second), .addr_lo(addr_lo), .addr_hi(addr_hi),
        .tx_word(tx_word), .timing(timing), .rb_in(rb_in), .io_in(io_in),
        .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .io_out(io_out),
        .io_oe(io_oe), .busy(busy), .done(done), .rx_word(rx_word)
    );

    always #4ns clk = ~clk;

    int total = 0, bad = 0;

    // monitor state
    int ncyc = 0, n = 0, done_cnt = 0, done_t = 0, ce_t = 0, wf_t = 0;
    int re_f_t = 0, re_r_t = 0, rx_i = 0;
    logic done_wide = 1'b0, done_prev = 1'b0, we_prev = 1'b1, re_prev = 1'b1;
    logic [NCHIP-1:0] ce_prev = '1;
    int ev_kind [32];
    int ev_fall [32];
    int ev_rise [32];
    logic [7:0] ev_byte [32];
    logic [7:0] rx_tbl [8];

    always @(negedge clk) begin
        ncyc++;
        if (ce_n != '1 && ce_prev == '1) ce_t = ncyc;
        if (!we_n && we_prev) wf_t = ncyc;
        if (we_n && !we_prev) begin
            if (n < 32) begin
                ev_kind[n] = cle ? 1 : (ale ? 2 : 3);
                ev_byte[n] = io_out;
                ev_fall[n] = wf_t;
                ev_rise[n] = ncyc;
            end
            n++;
        end
        if (!re_n && re_prev) begin
            io_in = rx_tbl[rx_i % 8];
            re_f_t = ncyc;
            rx_i++;
        end
        if (re_n && !re_prev) re_r_t = ncyc;
        if (done) begin
            done_cnt++;
            done_t = ncyc;
            if (done_prev) done_wide = 1'b1;
        end
        done_prev = done;
        we_prev = we_n;
        re_prev = re_n;
        ce_prev = ce_n;
    end

    function automatic logic [17:0] mk_tim(int wl, int wh, int rl, int rh, int su, int twb);
        return {4'(twb), 2'(su), 2'(rh), 4'(rl), 2'(wh), 4'(wl)};
    endfunction

    function automatic logic [31:0] f_len(int v);
        return 32'(v & 15) << 20;
    endfunction

    function automatic logic [31:0] f_ce(int chip);
        return 32'h100 << chip;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic chk_ev(input string req, input int i, input int kind, input logic [7:0] b);
        check(req, 64'(ev_kind[i]), 64'(kind));
        check(req, 64'(ev_byte[i]), 64'(b));
    endtask

    task automatic clear_log();
        n = 0; done_cnt = 0; rx_i = 0; done_wide = 1'b0;
    endtask

    task automatic start(input logic [31:0] c);
        @(negedge clk);
        cmd_word = c;
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int k;
        k = 0;
        while (done_cnt == 0 && k < 5000) begin
            @(negedge clk);
            k++;
        end
        repeat (3) @(negedge clk);
        check({req, " done seen"}, 64'(done_cnt != 0), 64'd1);
    endtask

    task automatic t_reset();
        check("R1 ce_n", 64'(ce_n), 64'hFF);
        check("R1 cle/ale", 64'({cle, ale}), 64'd0);
        check("R1 strobes", 64'({we_n, re_n}), 64'd3);
        check("R1 busy/done", 64'({busy, done}), 64'd0);
        check("R1 rx_word", 64'(rx_word), 64'd0);
    endtask

    task automatic t_read();
        int k;
        clear_log();
        timing = mk_tim(1, 1, 2, 1, 1, 2);
        op_first = 8'h00; op_second = 8'h30;
        addr_lo = 32'h4433_2211; addr_hi = 32'h0000_0055;
        rb_in = 1'b0;
        start(C_GO | C_CMD1 | C_ADDR | C_CMD2 | C_RBW | C_PIO | C_RX | f_len(3) | 32'd4 | f_ce(2));
        k = 0;
        while (n < 7 && k < 3000) begin @(negedge clk); k++; end
        repeat (80) @(negedge clk);
        check("R8 no done while rb low", 64'(done_cnt), 64'd0);
        check("R2 chip 2 selected", 64'(ce_n), 64'hFB);
        rb_in = 1'b1;
        wait_done("R8");
        check("R3 byte count", 64'(n), 64'd7);
        chk_ev("R3 first opcode", 0, 1, 8'h00);
        chk_ev("R3 addr b0", 1, 2, 8'h11);
        chk_ev("R3 addr b1", 2, 2, 8'h22);
        chk_ev("R3 addr b2", 3, 2, 8'h33);
        chk_ev("R3 addr b3", 4, 2, 8'h44);
        chk_ev("R3 addr b4 from hi", 5, 2, 8'h55);
        chk_ev("R4 second opcode before data", 6, 1, 8'h30);
        check("R6 rx word", 64'(rx_word), 64'hD4C3_B2A1);
        check("R9 single done", 64'({done_cnt[7:0], done_wide}), 64'h2);
        check("R2 ce released", 64'(ce_n), 64'hFF);
        check("R9 busy low", 64'(busy), 64'd0);
    endtask

    task automatic t_program();
        clear_log();
        timing = mk_tim(1, 1, 1, 1, 0, 0);
        op_first = 8'h80; op_second = 8'h10;
        addr_lo = 32'h0000_CDAB; tx_word = 32'h9977_6655;
        start(C_GO | C_CMD1 | C_ADDR | C_PIO | C_TX | C_CMD2 | C_LATE | f_len(2) | 32'd1 | f_ce(0));
        wait_done("R4");
        check("R5 byte count", 64'(n), 64'd7);
        chk_ev("R3 opcode", 0, 1, 8'h80);
        chk_ev("R3 addr b0", 1, 2, 8'hAB);
        chk_ev("R3 addr b1", 2, 2, 8'hCD);
        chk_ev("R5 tx lane0", 3, 3, 8'h55);
        chk_ev("R5 tx lane1", 4, 3, 8'h66);
        chk_ev("R5 tx lane2", 5, 3, 8'h77);
        chk_ev("R4 second opcode after data", 6, 1, 8'h10);
    endtask

    task automatic t_rx_short();
        clear_log();
        timing = mk_tim(1, 1, 4, 2, 0, 0);
        start(C_GO | C_PIO | C_RX | f_len(1) | f_ce(1));
        wait_done("R6");
        check("R6 no we strobes", 64'(n), 64'd0);
        check("R6 two lanes, upper zero", 64'(rx_word), 64'h0000_B2A1);
        check("R7 re low width", 64'(re_r_t - re_f_t), 64'd5);
    endtask

    task automatic t_timing();
        clear_log();
        rb_in = 1'b1;
        timing = mk_tim(5, 2, 1, 1, 3, 9);
        op_first = 8'h60; op_second = 8'hD0;
        start(C_GO | C_CMD1 | C_CMD2 | C_RBW | f_ce(0));
        wait_done("R7");
        check("R7 two events", 64'(n), 64'd2);
        check("R7 setup", 64'(ev_fall[0] - ce_t), 64'd4);
        check("R7 we low", 64'(ev_rise[0] - ev_fall[0]), 64'd6);
        check("R7 we high", 64'(ev_fall[1] - ev_rise[0]), 64'd3);
        check("R8 wait delay", 64'(done_t - ev_rise[1]), 64'd14);
    endtask

    task automatic t_addr8();
        clear_log();
        timing = mk_tim(0, 0, 0, 0, 0, 0);
        addr_lo = 32'h7654_3210; addr_hi = 32'hFEDC_BA98;
        start(C_GO | C_ADDR | 32'd15 | f_ce(7));
        wait_done("R3");
        check("R3 count clamps to 8", 64'(n), 64'd8);
        chk_ev("R3 a0", 0, 2, 8'h10);
        chk_ev("R3 a3", 3, 2, 8'h76);
        chk_ev("R3 a4", 4, 2, 8'h98);
        chk_ev("R3 a7", 7, 2, 8'hFE);
        check("R7 zero widths give one cycle", 64'(ev_rise[1] - ev_fall[1]), 64'd1);
    endtask

    task automatic t_tx_clamp();
        clear_log();
        timing = mk_tim(0, 1, 0, 0, 0, 0);
        tx_word = 32'h4433_2211;
        start(C_GO | C_PIO | C_TX | C_RX | f_len(9) | f_ce(4));
        wait_done("R5");
        check("R5 len clamps to 4", 64'(n), 64'd4);
        chk_ev("R5 lane0", 0, 3, 8'h11);
        chk_ev("R5 lane3", 3, 3, 8'h44);
    endtask

    task automatic t_no_pio();
        clear_log();
        op_first = 8'h5A;
        start(C_GO | C_CMD1 | C_TX | C_RX | f_len(3) | f_ce(0));
        wait_done("R11");
        check("R11 only opcode", 64'(n), 64'd1);
        chk_ev("R11 opcode", 0, 1, 8'h5A);
    endtask

    task automatic t_ignore();
        clear_log();
        timing = mk_tim(15, 3, 0, 0, 0, 0);
        addr_lo = 32'h0033_2211;
        start(C_GO | C_ADDR | 32'd2 | f_ce(1));
        repeat (5) @(negedge clk);
        start(C_GO | C_CMD1 | f_ce(3));
        check("R10 ce unchanged", 64'(ce_n), 64'hFD);
        check("R10 still busy", 64'(busy), 64'd1);
        wait_done("R10");
        check("R10 byte count", 64'(n), 64'd3);
        check("R10 no opcode", 64'({ev_kind[0], ev_kind[1], ev_kind[2]}), {32'd0, 32'd2} << 0 | 64'(96'({32'd2, 32'd2, 32'd2})));
        repeat (40) @(negedge clk);
        check("R10 no second done", 64'(done_cnt), 64'd1);
        check("R10 idle", 64'(busy), 64'd0);
        clear_log();
        start(C_CMD1 | f_ce(0));
        repeat (10) @(negedge clk);
        check("R10 go clear starts nothing", 64'({busy, 8'(n)}), 64'd0);
        check("R10 go clear ce", 64'(ce_n), 64'hFF);
    endtask

    initial begin
        rx_tbl[0] = 8'hA1; rx_tbl[1] = 8'hB2; rx_tbl[2] = 8'hC3; rx_tbl[3] = 8'hD4;
        rx_tbl[4] = 8'hE5; rx_tbl[5] = 8'hF6; rx_tbl[6] = 8'h07; rx_tbl[7] = 8'h18;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_read();
        t_program();
        t_rx_short();
        t_timing();
        t_addr8();
        t_tx_clamp();
        t_no_pio();
        t_ignore();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R9 act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule